// File: doc/BRIEF.md
# Asynchronous Parallel Register Bus Slave

This block sits behind a memory-style parallel port and turns it into single-cycle register accesses on a fast internal clock. It has an active-low select, an active-low read strobe and an active-low write strobe, six address lines and an 8-bit data path. The bidirectional data pins are represented by an input bus, an output bus and a drive enable. Every pin passes through a two-flop synchronizer, and all decoding happens on the synchronized copies. A read drives the data of the register on the address lines while the read conditions hold. A write is framed by the overlap of select and write strobe. It ends when the first of the two returns high, and it produces one write pulse that carries the address and data seen in the last cycle of the overlap.

A power-good input gates everything. While power is reported bad, no write pulse is issued and the data bus is not driven. When power returns, the port stays locked for a parameterised number of cycles. A second parameterised count sets how long the write strobe must have stayed high before the next access is accepted. The register storage itself is outside the block: read data comes in on `rd_data` for the address on `rd_addr`, and writes leave on the write pulse.

Top module: `regbus_slave`

## Requirements
- R1: With `cs_n`=0, `oe_n`=0, `we_n`=1, power good and the write-strobe recovery satisfied, `data_oe` is 1 and `data_out` equals `rd_data` within 4 cycles. When `data_oe` is 0, `data_out` is 0.
- R2: `rd_addr` follows the `addr` pins after two synchronizer cycles.
- R3: Each overlap of `cs_n`=0 and `we_n`=0 that is accepted gives exactly one single-cycle `wr_en` pulse after the overlap ends. `wr_addr` and `wr_data` hold the address and data present in the last cycle of the overlap, and data changed after the end is not used.
- R4: The overlap starts at whichever of `cs_n` and `we_n` falls last and ends at whichever rises first. This holds for both falling orders and for both rising orders.
- R5: When `we_n` goes low during an active read, `data_oe` returns to 0 within 4 cycles.
- R6: While `pwr_good` is 0, no `wr_en` pulse is issued and `data_oe` stays 0. A write whose overlap is cut by a power loss is dropped.
- R7: After `pwr_good` returns to 1, all accesses are ignored until it has been seen high for `PWR_REC` cycles. After that, reads and writes work normally.
- R8: An access is accepted only if `we_n` stayed high for at least `WE_REC` cycles in its most recent high interval. An overlap started after a shorter high pulse produces no `wr_en`.
- R9: After reset, `data_oe` and `wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Supply above trip level |
| cs_n | input | 1 | Active-low select |
| oe_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 6 | Register address |
| data_in | input | 8 | Data bus, incoming side |
| data_out | output | 8 | Data bus, outgoing side |
| data_oe | output | 1 | Data bus drive enable |
| rd_addr | output | 6 | Address presented to register storage |
| rd_data | input | 8 | Register contents at `rd_addr` |
| wr_en | output | 1 | Single-cycle write pulse |
| wr_addr | output | 6 | Address of the write |
| wr_data | output | 8 | Data of the write |

## Verification
The hardest case to reach from the pins is an overlap that is refused because the write strobe went high too briefly before the overlap began. The stimulus holds select low and gives the write strobe a one-cycle high pulse between two low phases. The first low phase must produce one write and the second none. A power loss in the middle of an open overlap is reached the same way: the overlap is opened, power is dropped before either strobe rises, and the strobes are then released. A read issued shortly after power returns, while the lockout count is still running, must stay undriven.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  // Read decode on active-low strobes
  function automatic logic is_read(logic cs_n, logic oe_n, logic we_n);
    return !cs_n && !oe_n && we_n;
  endfunction

  // Write overlap on active-low strobes
  function automatic logic is_write(logic cs_n, logic we_n);
    return !cs_n && !we_n;
  endfunction

  // Saturating increment used by both recovery counters
  function automatic int sat_next(int cur, int lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

endpackage

// File: rtl/regbus_sync.sv
module regbus_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/regbus_pwr_gate.sv
module regbus_pwr_gate #(
  parameter int REC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_s,
  output logic pwr_ok
);
  import regbus_pkg::*;
  localparam int CW = $clog2(REC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!pwr_s) cnt <= '0;
    else             cnt <= CW'(sat_next(int'(cnt), REC));
  end

  assign pwr_ok = (cnt == CW'(REC));

  AST_PWR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_s |=> !pwr_ok); // R6
  AST_PWR_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_ok) |-> $past(pwr_s)); // R7
endmodule

// File: rtl/regbus_write_frame.sv
module regbus_write_frame #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int WE_REC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              we_s,
  input  logic              pwr_ok,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] data_s,
  output logic              rec_ok,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  import regbus_pkg::*;
  localparam int RW = $clog2(WE_REC + 1);

  logic              wr_now, wr_prev, armed, we_prev;
  logic              wr_start, wr_end;
  logic [RW-1:0]     we_cnt;
  logic [ADDR_W-1:0] addr_prev;
  logic [DATA_W-1:0] data_prev;

  assign wr_now   = is_write(cs_s, we_s);
  assign wr_start = wr_now && !wr_prev;
  assign wr_end   = wr_prev && !wr_now;
  assign rec_ok   = (we_cnt == RW'(WE_REC));

  // Length of the latest write-strobe high interval, frozen while low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev <= 1'b1;
      we_cnt  <= '0;
    end else begin
      we_prev <= we_s;
      if (we_s) we_cnt <= we_prev ? RW'(sat_next(int'(we_cnt), WE_REC)) : RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev   <= 1'b0;
      armed     <= 1'b0;
      addr_prev <= '0;
      data_prev <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_prev   <= wr_now;
      addr_prev <= addr_s;
      data_prev <= data_s;
      if (!pwr_ok)       armed <= 1'b0;
      else if (wr_start) armed <= rec_ok;
      else if (wr_end)   armed <= 1'b0;
      wr_en <= wr_end && armed && pwr_ok;
      if (wr_end) begin
        wr_addr <= addr_prev;
        wr_data <= data_prev;
      end
    end
  end

  AST_WR_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(wr_end)); // R3
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R3
  AST_WR_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(pwr_ok)); // R6
endmodule

// File: rtl/regbus_slave.sv
module regbus_slave #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PWR_REC = 16,
  parameter int WE_REC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  import regbus_pkg::*;
  localparam int SW = 4 + ADDR_W + DATA_W;
  localparam logic [SW-1:0] SYNC_RST = {4'b0111, {(ADDR_W + DATA_W){1'b0}}};

  logic [SW-1:0]     pin_vec, syn_vec;
  logic              pwr_s, cs_s, oe_s, we_s, pwr_ok, rec_ok, read_cyc;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;

  assign pin_vec = {pwr_good, cs_n, oe_n, we_n, addr, data_in};
  assign {pwr_s, cs_s, oe_s, we_s, addr_s, data_s} = syn_vec;

  regbus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_vec), .q(syn_vec));

  regbus_pwr_gate #(.REC(PWR_REC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .pwr_s(pwr_s), .pwr_ok(pwr_ok));

  regbus_write_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WE_REC(WE_REC)) u_wr (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .we_s(we_s), .pwr_ok(pwr_ok),
    .addr_s(addr_s), .data_s(data_s), .rec_ok(rec_ok),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  assign read_cyc = is_read(cs_s, oe_s, we_s);
  assign data_oe  = read_cyc && pwr_ok && rec_ok;
  assign data_out = data_oe ? rd_data : '0;
  assign rd_addr  = addr_s;

  // Holds for WE_REC of 2 or more: the pulse cycle follows a fresh strobe rise
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !data_oe); // R5
  AST_DRIVE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> $past(pwr_s)); // R6
endmodule

// File: tb/regbus_slave_test.sv
module regbus_slave_test;
  logic clk = 0, rst_n = 0, pwr_good = 1;
  logic cs_n = 1, oe_n = 1, we_n = 1;
  logic [5:0] addr = 0;
  logic [7:0] data_in = 0;
  logic [7:0] data_out, rd_data, wr_data;
  logic [5:0] rd_addr, wr_addr;
  logic data_oe, wr_en;

  int checks = 0, errors = 0, wr_count = 0;
  logic [5:0] last_addr;
  logic [7:0] last_data;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] mem_val(logic [5:0] a);
    return {a[2:0], a[5:3], 2'b01} ^ 8'hC3;
  endfunction
  assign rd_data = mem_val(rd_addr);

  regbus_slave uut (.clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs_n(cs_n),
    .oe_n(oe_n), .we_n(we_n), .addr(addr), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data));

  always @(posedge clk) if (wr_en) begin
    wr_count++; last_addr <= wr_addr; last_data <= wr_data;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 data_oe", data_oe, 0);
    chk("R9 wr_en", wr_en, 0);
  endtask

  task automatic t_read(logic [5:0] a);
    addr = a; cs_n = 0; oe_n = 0; cyc(5);
    chk("R1 data_oe", data_oe, 1);
    chk("R1 data_out", data_out, mem_val(a));
    chk("R2 rd_addr", rd_addr, a);
    oe_n = 1; cyc(4);
    chk("R1 off data_oe", data_oe, 0);
    chk("R1 off data_out", data_out, 0);
    cs_n = 1; cyc(2);
  endtask

  // cs_first: select falls first; cs_rise_first: select rises first
  task automatic t_write(string req, bit cs_first, bit cs_rise_first,
                         logic [5:0] a, logic [7:0] d);
    int base = wr_count;
    addr = a; data_in = d;
    if (cs_first) cs_n = 0; else we_n = 0;
    cyc(3);
    if (cs_first) we_n = 0; else cs_n = 0;
    cyc(3);
    if (cs_rise_first) cs_n = 1; else we_n = 1;
    data_in = ~d;
    cyc(3);
    if (cs_rise_first) we_n = 1; else cs_n = 1;
    cyc(10);
    chk({req, " count"}, wr_count - base, 1);
    chk({req, " addr"}, last_addr, a);
    chk({req, " data"}, last_data, d);
  endtask

  task automatic t_we_kills_oe();
    addr = 6'h11; cs_n = 0; oe_n = 0; cyc(5);
    chk("R5 pre data_oe", data_oe, 1);
    we_n = 0; cyc(4);
    chk("R5 data_oe", data_oe, 0);
    oe_n = 1; we_n = 1; cs_n = 1; cyc(10);
  endtask

  task automatic t_we_recovery();
    int base = wr_count;
    addr = 6'h2A; data_in = 8'h66; cs_n = 0; cyc(2);
    we_n = 0; cyc(4);
    we_n = 1; cyc(1);
    data_in = 8'h99; we_n = 0; cyc(4);
    we_n = 1; cyc(3); cs_n = 1; cyc(10);
    chk("R8 count", wr_count - base, 1);
    chk("R8 data", last_data, 8'h66);
  endtask

  task automatic t_power_loss();
    int base = wr_count;
    addr = 6'h05; data_in = 8'h5A; cs_n = 0; we_n = 0; cyc(4);
    pwr_good = 0; cyc(4);
    we_n = 1; cs_n = 1; cyc(10);
    chk("R6 cut write", wr_count - base, 0);
    cs_n = 0; we_n = 0; cyc(4); we_n = 1; cs_n = 1; cyc(10);
    chk("R6 write blocked", wr_count - base, 0);
    cs_n = 0; oe_n = 0; cyc(10);
    chk("R6 no drive", data_oe, 0);
    oe_n = 1; cs_n = 1; cyc(2);
  endtask

  task automatic t_power_recovery();
    pwr_good = 1; cyc(3);
    addr = 6'h09; cs_n = 0; oe_n = 0; cyc(5);
    chk("R7 locked", data_oe, 0);
    oe_n = 1; cs_n = 1; cyc(30);
    t_read(6'h09);
    t_write("R7 write", 1, 0, 6'h22, 8'hE1);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1; cyc(30);
    t_read(6'h00);
    t_read(6'h3F);
    t_write("R3 write", 1, 0, 6'h12, 8'hA5);
    t_write("R4 we first", 0, 0, 6'h33, 8'h3C);
    t_write("R4 cs rises first", 1, 1, 6'h07, 8'h81);
    t_write("R4 we first cs rises", 0, 1, 6'h3E, 8'h10);
    t_we_kills_oe();
    t_we_recovery();
    t_power_loss();
    t_power_recovery();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule